// File: doc/BRIEF.md
# Calendar Clock with Time-of-Day Alarm

The block keeps time of day and a calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on the tick input moves the time forward by one second. Two mode inputs choose how the bytes are read and written. One picks BCD or binary encoding for every byte. The other picks 24-hour hours or 12-hour hours with a PM flag. A hold input stops the time from counting so that software can load a consistent set of values through the byte write port.

The clock has three alarm bytes, for seconds, minutes and hours. Any alarm byte whose two top bits are both set counts as "don't care". After every one-second update the block compares the new time against the alarm bytes. The alarm output is high for as long as that update matched.

A three-state machine sequences the work. In `ST_IDLE` the block accepts writes and waits for a tick. The transition *start* (tick high, hold low) moves it to `ST_STEP`. There the carry chain writes the incremented time into the registers, and the transition *advance* always goes on to `ST_MATCH`. In `ST_MATCH` the alarm output is recomputed from the new time, and the transition *finish* returns to `ST_IDLE`. Writes and ticks that arrive outside `ST_IDLE` are dropped.

Top module: `cal_clock`

## Requirements
- R1: After reset the outputs read seconds 00h, minutes 00h, hours 00h, day of week 01h, day of month 01h, month 01h, year 00h and alarm low. The three alarm bytes reset to 00h.
- R2: In `ST_IDLE` a write with `wr_en_i` high stores `wr_data_i` into the byte chosen by `wr_addr_i`, and the new value shows on the outputs one cycle later. The address map is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm. Any other address changes nothing.
- R3: If `tick_i` is high at an edge while the block is in `ST_IDLE` and `hold_i` is low, the time advances by exactly one second. The new values appear on the outputs after the following edge.
- R4: While `hold_i` is high, a tick in `ST_IDLE` is ignored and the time fields do not change.
- R5: Seconds and minutes count 0 to 59 and then wrap to 0 with a carry. In BCD mode (`bin_mode_i`=0) 59 is 59h. In binary mode (`bin_mode_i`=1) 59 is 3Bh.
- R6: With `h24_mode_i`=1 the hours count 0 to 23, and the wrap from 23 to 0 carries into the day. With `h24_mode_i`=0, bit 7 of the hours byte is PM and bits 6:0 hold 1 to 12. The sequence runs 11 AM to 12 PM to 1 PM, and 11 PM to 12 AM, and the step to 12 AM carries into the day. In BCD the first sequence is 11h, 92h, 81h and the second is 91h to 12h. In binary 11 AM (0Bh) steps to 8Ch.
- R7: A day carry advances the day of week, which runs from 1 to 7 and then wraps to 1.
- R8: A day carry advances the day of month, which wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days.
- R9: The wrap of the day of month advances the month, which runs 1 to 12 and then wraps to 1. The wrap of the month advances the year, which runs 0 to 99 and then wraps to 0.
- R10: Two edges after an accepted tick, `alarm_o` becomes 1 exactly when each alarm byte either has bits 7:6 = 11b or equals the new value of its time byte (seconds, minutes, hours). It holds that value until the next update.
- R11: Writes and ticks that arrive while an update is in progress (`ST_STEP` or `ST_MATCH`) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance pulse |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| hold_i | input | 1 | Inhibits counting while high |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 4 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |
| alarm_o | output | 1 | Alarm match from the last update |

## Verification
The assertions assume three things about the inputs. Ticks are single pulses at least three cycles apart. Every byte loaded into the time registers is valid in the encoding and hour form that are active. The mode bits change only while no update is running. The bench drives ticks through one task that leaves several idle cycles after each pulse. It switches modes only between operations and writes only valid dates. The one exception is a deliberate write and second tick placed inside an update window, which tests that both are dropped.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 7;
    localparam int NUM_TIME = 7;
    localparam int NUM_ALM  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_MATCH = 2'd2
    } cal_state_e;

    // field slots, also the write addresses
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DOM  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;
    localparam int ALM_BASE = 8;

    function automatic logic [VAL_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
        return ({3'd0, v[7:4]} * 7'd10) + {3'd0, v[3:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [VAL_W-1:0] n);
        logic [BYTE_W-1:0] w;
        w = {1'b0, n};
        return ((w / 8'd10) << 4) | (w % 8'd10);
    endfunction

    function automatic logic [VAL_W-1:0] dec8(input logic [BYTE_W-1:0] v, input logic bin);
        return bin ? v[6:0] : bcd_to_bin(v);
    endfunction

    function automatic logic [BYTE_W-1:0] enc8(input logic [VAL_W-1:0] n, input logic bin);
        return bin ? {1'b0, n} : bin_to_bcd(n);
    endfunction

endpackage

// File: rtl/cal_field_step.sv
module cal_field_step
    import cal_pkg::*;
#(
    parameter int LO = 0
) (
    input  logic [BYTE_W-1:0] cur_i,
    input  logic [VAL_W-1:0]  hi_i,
    input  logic              bin_i,
    input  logic              en_i,
    output logic [BYTE_W-1:0] nxt_o,
    output logic              carry_o
);
    localparam logic [VAL_W-1:0] LO_V = VAL_W'(LO);

    logic [VAL_W-1:0] val;
    logic             at_top;

    always_comb begin
        val     = dec8(cur_i, bin_i);
        at_top  = (val >= hi_i);
        carry_o = en_i && at_top;
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (at_top) begin
            nxt_o = enc8(LO_V, bin_i);
        end else begin
            nxt_o = enc8(val + 7'd1, bin_i);
        end
    end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_pkg::*;
(
    input  logic [BYTE_W-1:0] cur_i,
    input  logic              bin_i,
    input  logic              h24_i,
    input  logic              en_i,
    output logic [BYTE_W-1:0] nxt_o,
    output logic              carry_o
);
    logic [VAL_W-1:0]  h12;
    logic [VAL_W-1:0]  day_h;
    logic [VAL_W-1:0]  next_h;
    logic [VAL_W-1:0]  disp_h;
    logic [BYTE_W-1:0] coded;
    logic              wrap;

    always_comb begin
        // bring the byte to a 0..23 count
        h12 = dec8({1'b0, cur_i[6:0]}, bin_i);
        if (h24_i) begin
            day_h = dec8(cur_i, bin_i);
        end else begin
            day_h = ((h12 == 7'd12) ? 7'd0 : h12) + (cur_i[7] ? 7'd12 : 7'd0);
        end
        wrap    = (day_h >= 7'd23);
        carry_o = en_i && wrap;
        next_h  = wrap ? 7'd0 : day_h + 7'd1;
        // back to the selected form
        if (h24_i) begin
            disp_h = next_h;
        end else if (next_h >= 7'd12) begin
            disp_h = (next_h == 7'd12) ? 7'd12 : next_h - 7'd12;
        end else begin
            disp_h = (next_h == 7'd0) ? 7'd12 : next_h;
        end
        coded = enc8(disp_h, bin_i);
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (h24_i) begin
            nxt_o = coded;
        end else begin
            nxt_o = {(next_h >= 7'd12), coded[6:0]};
        end
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  logic [BYTE_W-1:0] mon_i,
    input  logic [BYTE_W-1:0] year_i,
    input  logic              bin_i,
    output logic [VAL_W-1:0]  last_day_o
);
    logic [VAL_W-1:0] m;
    logic [VAL_W-1:0] y;

    always_comb begin
        m = dec8(mon_i, bin_i);
        y = dec8(year_i, bin_i);
        unique case (m)
            7'd2:                       last_day_o = ((y % 7'd4) == 7'd0) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    last_day_o = 7'd30;
            default:                    last_day_o = 7'd31;
        endcase
    end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_pkg::*;
#(
    parameter int N = NUM_ALM
) (
    input  logic [N-1:0][BYTE_W-1:0] alm_i,
    input  logic [N-1:0][BYTE_W-1:0] time_i,
    output logic                     hit_o
);
    logic [N-1:0] lane_ok;

    for (genvar k = 0; k < N; k++) begin : g_lane
        assign lane_ok[k] = (alm_i[k][7:6] == 2'b11) || (alm_i[k] == time_i[k]);
    end

    assign hit_o = &lane_ok;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bin_mode_i,
    input  logic              h24_mode_i,
    input  logic              hold_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        sec_o,
    output logic [7:0]        min_o,
    output logic [7:0]        hour_o,
    output logic [7:0]        dow_o,
    output logic [7:0]        dom_o,
    output logic [7:0]        mon_o,
    output logic [7:0]        year_o,
    output logic              alarm_o
);
    cal_state_e state_q, state_d;

    logic [NUM_TIME-1:0][BYTE_W-1:0] fld_q;
    logic [NUM_TIME-1:0][BYTE_W-1:0] fld_nxt;
    logic [NUM_ALM-1:0][BYTE_W-1:0]  alm_q;
    logic [NUM_ALM-1:0][BYTE_W-1:0]  alm_time;
    logic                            alarm_q;

    logic c_sec, c_min, c_hour, c_dom, c_mon, c_dow, c_year;
    logic [VAL_W-1:0] last_day;
    logic             hit;

    // carry chain
    cal_field_step #(.LO(0)) u_sec (
        .cur_i(fld_q[F_SEC]), .hi_i(7'd59), .bin_i(bin_mode_i), .en_i(1'b1),
        .nxt_o(fld_nxt[F_SEC]), .carry_o(c_sec));

    cal_field_step #(.LO(0)) u_min (
        .cur_i(fld_q[F_MIN]), .hi_i(7'd59), .bin_i(bin_mode_i), .en_i(c_sec),
        .nxt_o(fld_nxt[F_MIN]), .carry_o(c_min));

    cal_hour_step u_hour (
        .cur_i(fld_q[F_HOUR]), .bin_i(bin_mode_i), .h24_i(h24_mode_i), .en_i(c_min),
        .nxt_o(fld_nxt[F_HOUR]), .carry_o(c_hour));

    cal_field_step #(.LO(1)) u_dow (
        .cur_i(fld_q[F_DOW]), .hi_i(7'd7), .bin_i(bin_mode_i), .en_i(c_hour),
        .nxt_o(fld_nxt[F_DOW]), .carry_o(c_dow));

    cal_month_len u_mlen (
        .mon_i(fld_q[F_MON]), .year_i(fld_q[F_YEAR]), .bin_i(bin_mode_i),
        .last_day_o(last_day));

    cal_field_step #(.LO(1)) u_dom (
        .cur_i(fld_q[F_DOM]), .hi_i(last_day), .bin_i(bin_mode_i), .en_i(c_hour),
        .nxt_o(fld_nxt[F_DOM]), .carry_o(c_dom));

    cal_field_step #(.LO(1)) u_mon (
        .cur_i(fld_q[F_MON]), .hi_i(7'd12), .bin_i(bin_mode_i), .en_i(c_dom),
        .nxt_o(fld_nxt[F_MON]), .carry_o(c_mon));

    cal_field_step #(.LO(0)) u_year (
        .cur_i(fld_q[F_YEAR]), .hi_i(7'd99), .bin_i(bin_mode_i), .en_i(c_mon),
        .nxt_o(fld_nxt[F_YEAR]), .carry_o(c_year));

    // alarm compare against the already-updated time registers
    for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm_src
        assign alm_time[k] = fld_q[F_SEC + k];
    end

    cal_alarm_cmp #(.N(NUM_ALM)) u_cmp (
        .alm_i(alm_q), .time_i(alm_time), .hit_o(hit));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick_i && !hold_i) state_d = ST_STEP;
            ST_STEP:  state_d = ST_MATCH;
            ST_MATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // data and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q           <= '0;
            fld_q[F_DOW]    <= 8'h01;
            fld_q[F_DOM]    <= 8'h01;
            fld_q[F_MON]    <= 8'h01;
            alm_q           <= '0;
            alarm_q         <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en_i) begin
                        for (int i = 0; i < NUM_TIME; i++) begin
                            if (wr_addr_i == ADDR_W'(i)) fld_q[i] <= wr_data_i;
                        end
                        for (int j = 0; j < NUM_ALM; j++) begin
                            if (wr_addr_i == ADDR_W'(ALM_BASE + j)) alm_q[j] <= wr_data_i;
                        end
                    end
                end
                ST_STEP:  fld_q   <= fld_nxt;
                ST_MATCH: alarm_q <= hit;
                default: ;
            endcase
        end
    end

    assign sec_o   = fld_q[F_SEC];
    assign min_o   = fld_q[F_MIN];
    assign hour_o  = fld_q[F_HOUR];
    assign dow_o   = fld_q[F_DOW];
    assign dom_o   = fld_q[F_DOM];
    assign mon_o   = fld_q[F_MON];
    assign year_o  = fld_q[F_YEAR];
    assign alarm_o = alarm_q;

    // wrap flags beyond the chain end have no consumer
    logic unused_carry;
    assign unused_carry = c_dow ^ c_year;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cal_state_e state_q,
    input logic       tick_i,
    input logic       hold_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] dow_o,
    input logic [7:0] dom_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o,
    input logic       alarm_o,
    input logic [NUM_ALM-1:0][BYTE_W-1:0] alm_q
);
    logic [55:0] all_f;
    assign all_f = {sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o};

    p_tick_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tick_i && !hold_i) |=> (state_q == ST_STEP));

    p_step_moves_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (sec_o != $past(sec_o)));

    p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hold_i) |=> (state_q == ST_IDLE));

    p_alarm_only_on_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_MATCH) |=> $stable(alarm_o));

    p_dont_care_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH && alm_q[0][7:6] == 2'b11 && alm_q[1][7:6] == 2'b11
         && alm_q[2][7:6] == 2'b11) |=> alarm_o);

    p_busy_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MATCH) |=> $stable(all_f));

    p_busy_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (state_q == ST_MATCH));
endmodule

bind cal_clock cal_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .tick_i(tick_i), .hold_i(hold_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .dom_o(dom_o),
    .mon_o(mon_o), .year_o(year_o), .alarm_o(alarm_o), .alm_q(alm_q));

// File: tb/cal_clock_tb_top.sv
module cal_clock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       bin_mode_i = 1'b0;
    logic       h24_mode_i = 1'b1;
    logic       hold_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o;
    logic       alarm_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    cal_clock dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bin_mode_i(bin_mode_i),
        .h24_mode_i(h24_mode_i), .hold_i(hold_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .dow_o(dow_o), .dom_o(dom_o), .mon_o(mon_o),
        .year_o(year_o), .alarm_o(alarm_o));

    // ---------------- reference model ----------------
    int mb[7];
    int ma[3];
    int phase = 0;
    bit m_alarm = 0;

    function automatic int dec(int v, bit bin);
        if (bin) return v & 127;
        return ((v / 16) % 16) * 10 + (v % 16);
    endfunction

    function automatic int enc(int n, bit bin);
        if (bin) return n;
        return (n / 10) * 16 + (n % 10);
    endfunction

    function automatic int hdec(int v, bit bin, bit h24);
        int hh;
        if (h24) return dec(v, bin);
        hh = dec(v % 128, bin) % 12;
        return (v >= 128) ? hh + 12 : hh;
    endfunction

    function automatic int henc(int n, bit bin, bit h24);
        int hh;
        if (h24) return enc(n, bin);
        hh = n % 12;
        if (hh == 0) hh = 12;
        return enc(hh, bin) + ((n >= 12) ? 128 : 0);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_advance(bit bin, bit h24);
        int s, mi, h, dw, dd, mo, yr, ml;
        s = dec(mb[0], bin); mi = dec(mb[1], bin); h = hdec(mb[2], bin, h24);
        dw = dec(mb[3], bin); dd = dec(mb[4], bin); mo = dec(mb[5], bin); yr = dec(mb[6], bin);
        ml = days_in(mo, yr);
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0;
                    dw = (dw == 7) ? 1 : dw + 1;
                    dd++;
                    if (dd > ml) begin
                        dd = 1; mo++;
                        if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
                    end
                    mb[3] = enc(dw, bin); mb[4] = enc(dd, bin);
                    mb[5] = enc(mo, bin); mb[6] = enc(yr, bin);
                end
                mb[2] = henc(h, bin, h24);
            end
            mb[1] = enc(mi, bin);
        end
        mb[0] = enc(s, bin);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mb = '{0, 0, 0, 1, 1, 1, 0};
            ma = '{0, 0, 0};
            phase = 0; m_alarm = 0;
        end else begin
            case (phase)
                0: begin
                    if (wr_en_i) begin
                        if (wr_addr_i <= 6) mb[wr_addr_i] = wr_data_i;
                        else if (wr_addr_i >= 8 && wr_addr_i <= 10) ma[wr_addr_i - 8] = wr_data_i;
                    end
                    if (tick_i && !hold_i) phase = 1;
                end
                1: begin model_advance(bin_mode_i, h24_mode_i); phase = 2; end
                default: begin
                    m_alarm = 1;
                    for (int k = 0; k < 3; k++)
                        if (!(ma[k] >= 'hC0 || ma[k] == mb[k])) m_alarm = 0;
                    phase = 0;
                end
            endcase
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, sec_o,  mb[0], "model sec");
            chk(cur_req, min_o,  mb[1], "model min");
            chk(cur_req, hour_o, mb[2], "model hour");
            chk(cur_req, dow_o,  mb[3], "model dow");
            chk(cur_req, dom_o,  mb[4], "model dom");
            chk(cur_req, mon_o,  mb[5], "model mon");
            chk(cur_req, year_o, mb[6], "model year");
            chk(cur_req, alarm_o, m_alarm, "model alarm");
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, int d);
        @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic set_time(int s, int mi, int h, int dw, int dd, int mo, int yr);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dd); wr(5, mo); wr(6, yr);
    endtask

    task automatic tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic modes(bit bin, bit h24);
        @(negedge clk); bin_mode_i = bin; h24_mode_i = h24;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", sec_o, 'h00, "reset sec"); chk("R1", hour_o, 'h00, "reset hour");
        chk("R1", dow_o, 'h01, "reset dow"); chk("R1", mon_o, 'h01, "reset mon");
        chk("R1", alarm_o, 0, "reset alarm");

        cur_req = "R2";
        wr(0, 'h42);
        chk("R2", sec_o, 'h42, "write sec");
        wr(7, 'h55);
        chk("R2", sec_o, 'h42, "unused addr"); chk("R2", dom_o, 'h01, "unused addr dom");

        // full rollover, BCD 24h
        cur_req = "R9";
        modes(0, 1);
        set_time('h59, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99);
        tick();
        chk("R5", sec_o, 'h00, "bcd sec wrap"); chk("R6", hour_o, 'h00, "24h wrap");
        chk("R7", dow_o, 'h01, "dow wrap"); chk("R8", dom_o, 'h01, "dom wrap");
        chk("R9", mon_o, 'h01, "mon wrap"); chk("R9", year_o, 'h00, "year wrap");

        // binary, non-leap February
        cur_req = "R8";
        modes(1, 1);
        set_time(59, 59, 23, 3, 28, 2, 23);
        tick();
        chk("R8", dom_o, 1, "bin feb28 nonleap"); chk("R8", mon_o, 3, "bin mar");
        chk("R5", min_o, 0, "bin min wrap");

        // BCD leap February
        modes(0, 1);
        set_time('h59, 'h59, 'h23, 'h02, 'h28, 'h02, 'h24);
        tick();
        chk("R8", dom_o, 'h29, "leap feb29");
        set_time('h59, 'h59, 'h23, 'h02, 'h29, 'h02, 'h24);
        tick();
        chk("R8", dom_o, 'h01, "leap end"); chk("R8", mon_o, 'h03, "leap mar");
        set_time('h59, 'h59, 'h23, 'h02, 'h30, 'h04, 'h24);
        tick();
        chk("R8", mon_o, 'h05, "30-day month");

        // 12-hour BCD
        cur_req = "R6";
        modes(0, 0);
        set_time('h59, 'h59, 'h11, 'h02, 'h05, 'h03, 'h10);
        tick();
        chk("R6", hour_o, 'h92, "11am->12pm");
        tick();
        set_time('h59, 'h59, 'h92, 'h02, 'h05, 'h03, 'h10);
        tick();
        chk("R6", hour_o, 'h81, "12pm->1pm");
        set_time('h59, 'h59, 'h91, 'h02, 'h05, 'h03, 'h10);
        tick();
        chk("R6", hour_o, 'h12, "11pm->12am"); chk("R6", dom_o, 'h06, "12am day carry");
        // 12-hour binary
        modes(1, 0);
        set_time(59, 59, 'h0B, 2, 5, 3, 10);
        tick();
        chk("R6", hour_o, 'h8C, "bin 11am->12pm");

        // hold
        cur_req = "R4";
        modes(0, 1);
        set_time('h10, 'h00, 'h05, 'h01, 'h01, 'h01, 'h01);
        @(negedge clk); hold_i = 1'b1;
        tick();
        chk("R4", sec_o, 'h10, "hold freezes");
        @(negedge clk); hold_i = 1'b0;
        cur_req = "R3";
        tick();
        chk("R3", sec_o, 'h11, "tick advances one");

        // alarm
        cur_req = "R10";
        wr(8, 'h05); wr(9, 'hC0); wr(10, 'hFF);
        wr(0, 'h04);
        tick();
        chk("R10", alarm_o, 1, "alarm match with dont-care");
        tick();
        chk("R10", alarm_o, 0, "alarm clears on miss");
        wr(9, 'h30); wr(0, 'h04);
        tick();
        chk("R10", alarm_o, 0, "alarm minute mismatch");

        // write and tick during update
        cur_req = "R11";
        wr(0, 'h20);
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 8'h33;
        @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", sec_o, 'h21, "busy write and tick dropped");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule